// File: doc/BRIEF.md
# Sleep and Idle Power-Mode Controller

This block decides which clocks of a processor subsystem run. From the normal run state it accepts a single power-save command whose argument picks one of two low-power modes. In the light mode (idle) only the CPU clock is stopped and the peripherals keep running. In the deep mode (sleep) the CPU and peripheral clocks stop and the on-chip main oscillator is switched off. The low-power RC clock that times the watchdog keeps running only when the watchdog is enabled.

A wake event ends sleep. The events are an enabled interrupt at sufficient priority, a non-power-on reset request, or a watchdog timeout while the watchdog is enabled. The controller then restarts the clock source that was selected when sleep was entered, and holds the system clock off through a chain of start-up delays that depends on the type of that source. Fast sources (an external clock, the fast internal RC, or a low-power oscillator kept alive through sleep) wait only the short power-on delay. Crystal sources also wait for the oscillator start-up timer and the power-up timer. A crystal feeding the PLL also waits for the lock timer and the lock signal.

If the oscillator is still not running when the delays end, the controller does one of two things. With fail-safe monitoring enabled, it raises a one-cycle clock-failure trap and moves to the internal fast RC clock. Otherwise it stays halted until the oscillator becomes ready. Sticky status flags record a sleep wake and a watchdog wake. All delays are counted in cycles of the free-running reference clock `clk`, and the oscillator and PLL are modelled by their ready and lock inputs.

Top module: `pwr_mode_ctl`

## Requirements
- R1: In run, a pulse on `cmd_valid` enters sleep when `cmd_sleep`=1 and idle when `cmd_sleep`=0, effective the next cycle. `src_sel` is captured when the command is accepted. `cmd_valid` outside run has no effect on the mode.
- R2: In idle, `cpu_clk_en`=0 and `per_clk_en`=1. An asserted `irq_wake` or `ext_rst` returns to run on the next clock edge.
- R3: In sleep, `cpu_clk_en`=0, `per_clk_en`=0 and `lprc_en` equals `wdt_en`. `osc_en`=0 unless the captured source is the low-power oscillator (`src_sel`=3) with `lp_hold`=1 and the controller is not on the fallback clock.
- R4: Sleep is left only on `irq_wake`, `ext_rst`, or `wdt_timeout` with `wdt_en`=1. A timeout while `wdt_en`=0 is ignored.
- R5: For a short-path source, `cpu_clk_en` rises T_POR cycles after the wake edge. The short-path sources are `src_sel`=0 (fast clock), `src_sel`=3 with `lp_hold`=1, and any source once `on_frc`=1.
- R6: For a crystal source (`src_sel`=1, or `src_sel`=3 with `lp_hold`=0) with `osc_ready`=1, `cpu_clk_en` rises T_POR+T_OST+T_PWRT cycles after the wake edge.
- R7: For the PLL source (`src_sel`=2), the lock delay T_LOCK is added to the R6 sequence, and the clock is released only if `pll_lock`=1 as well as `osc_ready`=1.
- R8: `slp_flag` is set by every wake from sleep and by `ext_rst` in any mode. `wdt_flag` is set by a wake from sleep caused by the watchdog. Both flags are cleared only by power-on reset `rst_n`.
- R9: If the source is not ready when the last delay ends and `fscm_en`=1, `fail_trap` pulses for exactly one cycle, `on_frc` is set, and the controller returns to run. Later wakes then take the short path.
- R10: If the source is not ready when the last delay ends and `fscm_en`=0, `cpu_clk_en` stays 0 until the source is ready, and run follows on the next edge.
- R11: After power-on reset the controller is in run with `cpu_clk_en`, `per_clk_en` and `osc_en` at 1, and `slp_flag`, `wdt_flag`, `on_frc` and `fail_trap` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst | input | 1 | Non-power-on reset request (wakes from sleep) |
| cmd_valid | input | 1 | Power-save command strobe |
| cmd_sleep | input | 1 | Command argument: 1 sleep, 0 idle |
| src_sel | input | 2 | Clock source type: 0 fast, 1 crystal, 2 crystal with PLL, 3 low-power osc |
| lp_hold | input | 1 | Low-power oscillator kept running through sleep |
| irq_wake | input | 1 | Enabled interrupt meeting current priority |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog timeout pulse |
| osc_ready | input | 1 | Oscillator running and stable |
| pll_lock | input | 1 | PLL locked |
| fscm_en | input | 1 | Fail-safe clock monitoring enabled |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Main on-chip oscillator enable |
| lprc_en | output | 1 | Low-power RC clock enable |
| slp_flag | output | 1 | Sticky sleep status flag |
| wdt_flag | output | 1 | Sticky watchdog-wake flag |
| on_frc | output | 1 | Fallback to internal fast RC active |
| fail_trap | output | 1 | One-cycle clock-failure trap |

## Verification
The wake path is exercised with one vector per source type: fast, crystal, crystal with PLL, low-power oscillator held, and low-power oscillator not held. Each vector measures the cycles from the wake edge to CPU clock release. The distinct counts show which start-up timers each source type chains. Directed cases separate the two not-ready outcomes: a halt that lasts until ready arrives, and a trap followed by the fast fallback, after which a crystal wake must shrink to the short delay. Further cases cover wakes by the watchdog versus a masked timeout, reset-driven wakes, idle entry and exit, commands ignored outside run, and flag clearing by power-on reset.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   typedef enum logic [2:0] {
      PM_RUN   = 3'd0,
      PM_IDLE  = 3'd1,
      PM_SLEEP = 3'd2,
      PM_WPOR  = 3'd3,
      PM_WOST  = 3'd4,
      PM_WLOCK = 3'd5,
      PM_WPWRT = 3'd6,
      PM_WHOLD = 3'd7
   } pm_state_e;

   typedef enum logic [1:0] {
      SRC_FAST = 2'd0,
      SRC_XTAL = 2'd1,
      SRC_PLL  = 2'd2,
      SRC_LP   = 2'd3
   } clk_src_e;
endpackage

// File: rtl/pmc_delay_timer.sv
module pmc_delay_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

   // counter never wraps: a nonzero value only ever steps down by one
   AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !done) |=> (cnt == $past(cnt) - 1'b1)); // R6
endmodule

// File: rtl/pmc_wake_detect.sv
module pmc_wake_detect (
   input  logic in_sleep,
   input  logic in_idle,
   input  logic irq_wake,
   input  logic ext_rst,
   input  logic wdt_en,
   input  logic wdt_timeout,
   output logic wake_sleep,
   output logic wake_idle,
   output logic wake_wdt
);
   logic wdt_hit;
   assign wdt_hit    = wdt_en && wdt_timeout;
   assign wake_sleep = in_sleep && (irq_wake || ext_rst || wdt_hit);
   assign wake_idle  = in_idle && (irq_wake || ext_rst);
   assign wake_wdt   = in_sleep && wdt_hit;
endmodule

// File: rtl/pmc_status.sv
module pmc_status (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_rst,
   input  logic sleep_wake,
   input  logic wdt_wake,
   input  logic fail_evt,
   output logic slp_flag,
   output logic wdt_flag,
   output logic on_frc,
   output logic fail_trap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slp_flag  <= 1'b0;
         wdt_flag  <= 1'b0;
         on_frc    <= 1'b0;
         fail_trap <= 1'b0;
      end else begin
         if (ext_rst || sleep_wake) slp_flag <= 1'b1;
         if (wdt_wake)              wdt_flag <= 1'b1;
         if (fail_evt)              on_frc   <= 1'b1;
         fail_trap <= fail_evt;
      end
   end

   AST_SLP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      slp_flag |=> slp_flag); // R8
   AST_WDT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_flag |=> wdt_flag); // R8
   AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fail_trap |=> !fail_trap); // R9
   AST_TRAP_FRC: assert property (@(posedge clk) disable iff (!rst_n)
      fail_trap |-> on_frc); // R9
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
   import pmc_pkg::*;
#(
   parameter int T_POR  = 3,
   parameter int T_OST  = 5,
   parameter int T_LOCK = 4,
   parameter int T_PWRT = 6,
   parameter int CNT_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_sleep,
   input  logic [1:0]       src_sel,
   input  logic             lp_hold,
   input  logic             wake_sleep,
   input  logic             wake_idle,
   input  logic             osc_ready,
   input  logic             pll_lock,
   input  logic             fscm_on,
   input  logic             on_frc,
   input  logic             tmr_done,
   output pm_state_e        cur,
   output clk_src_e         src_q,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             fail_evt
);
   pm_state_e nxt;
   logic      short_path;
   logic      ready_ok;

   assign short_path = on_frc || (src_q == SRC_FAST) ||
                       ((src_q == SRC_LP) && lp_hold);
   assign ready_ok   = osc_ready && ((src_q != SRC_PLL) || pll_lock);

   always_comb begin
      nxt      = cur;
      fail_evt = 1'b0;
      unique case (cur)
         PM_RUN:   if (cmd_valid) nxt = cmd_sleep ? PM_SLEEP : PM_IDLE;
         PM_IDLE:  if (wake_idle) nxt = PM_RUN;
         PM_SLEEP: if (wake_sleep) nxt = PM_WPOR;
         PM_WPOR:  if (tmr_done) nxt = short_path ? PM_RUN : PM_WOST;
         PM_WOST:  if (tmr_done) nxt = (src_q == SRC_PLL) ? PM_WLOCK : PM_WPWRT;
         PM_WLOCK: if (tmr_done) nxt = PM_WPWRT;
         PM_WPWRT: if (tmr_done) begin
            if (ready_ok)     nxt = PM_RUN;
            else if (fscm_on) begin
               nxt      = PM_RUN;
               fail_evt = 1'b1;
            end else          nxt = PM_WHOLD;
         end
         PM_WHOLD: if (ready_ok) nxt = PM_RUN;
         default:  nxt = PM_RUN;
      endcase
   end

   always_comb begin
      tmr_load = (nxt != cur);
      unique case (nxt)
         PM_WPOR:  tmr_val = CNT_W'(T_POR - 1);
         PM_WOST:  tmr_val = CNT_W'(T_OST - 1);
         PM_WLOCK: tmr_val = CNT_W'(T_LOCK - 1);
         PM_WPWRT: tmr_val = CNT_W'(T_PWRT - 1);
         default:  tmr_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur   <= PM_RUN;
         src_q <= SRC_FAST;
      end else begin
         cur <= nxt;
         if (cur == PM_RUN && cmd_valid && cmd_sleep) src_q <= clk_src_e'(src_sel);
      end
   end

   AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == PM_IDLE && wake_idle) |=> (cur == PM_RUN)); // R2
   AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == PM_SLEEP && !wake_sleep) |=> (cur == PM_SLEEP)); // R4
   AST_SHORT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == PM_WPOR && tmr_done && short_path) |=> (cur == PM_RUN)); // R5
   AST_PLL_LOCK_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == PM_WOST && tmr_done && src_q == SRC_PLL) |=> (cur == PM_WLOCK)); // R7
   AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == PM_WHOLD && !ready_ok) |=> (cur == PM_WHOLD)); // R10
   AST_CMD_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == PM_IDLE && !wake_idle) |=> (cur == PM_IDLE)); // R1
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
   import pmc_pkg::*;
#(
   parameter int T_POR        = 3,
   parameter int T_OST        = 5,
   parameter int T_LOCK       = 4,
   parameter int T_PWRT       = 6,
   parameter bit HAS_FAILSAFE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ext_rst,
   input  logic       cmd_valid,
   input  logic       cmd_sleep,
   input  logic [1:0] src_sel,
   input  logic       lp_hold,
   input  logic       irq_wake,
   input  logic       wdt_en,
   input  logic       wdt_timeout,
   input  logic       osc_ready,
   input  logic       pll_lock,
   input  logic       fscm_en,
   output logic       cpu_clk_en,
   output logic       per_clk_en,
   output logic       osc_en,
   output logic       lprc_en,
   output logic       slp_flag,
   output logic       wdt_flag,
   output logic       on_frc,
   output logic       fail_trap
);
   localparam int T_MAX_A = (T_POR > T_OST) ? T_POR : T_OST;
   localparam int T_MAX_B = (T_LOCK > T_PWRT) ? T_LOCK : T_PWRT;
   localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
   localparam int CNT_W   = $clog2(T_MAX + 1);

   if (T_POR < 1 || T_OST < 1 || T_LOCK < 1 || T_PWRT < 1) begin : g_bad_delay
      $error("pwr_mode_ctl: every delay parameter must be at least one cycle");
   end

   pm_state_e        cur;
   clk_src_e         src_q;
   logic             tmr_load, tmr_done, fail_evt, fscm_on;
   logic [CNT_W-1:0] tmr_val;
   logic             wake_sleep, wake_idle, wake_wdt;

   if (HAS_FAILSAFE) begin : g_fs
      assign fscm_on = fscm_en;
   end else begin : g_no_fs
      assign fscm_on = 1'b0;
   end

   pmc_wake_detect u_wake (
      .in_sleep   (cur == PM_SLEEP),
      .in_idle    (cur == PM_IDLE),
      .irq_wake   (irq_wake),
      .ext_rst    (ext_rst),
      .wdt_en     (wdt_en),
      .wdt_timeout(wdt_timeout),
      .wake_sleep (wake_sleep),
      .wake_idle  (wake_idle),
      .wake_wdt   (wake_wdt)
   );

   pmc_delay_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_val(tmr_val),
      .done    (tmr_done)
   );

   pmc_fsm #(
      .T_POR(T_POR), .T_OST(T_OST), .T_LOCK(T_LOCK), .T_PWRT(T_PWRT), .CNT_W(CNT_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_sleep (cmd_sleep),
      .src_sel   (src_sel),
      .lp_hold   (lp_hold),
      .wake_sleep(wake_sleep),
      .wake_idle (wake_idle),
      .osc_ready (osc_ready),
      .pll_lock  (pll_lock),
      .fscm_on   (fscm_on),
      .on_frc    (on_frc),
      .tmr_done  (tmr_done),
      .cur       (cur),
      .src_q     (src_q),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val),
      .fail_evt  (fail_evt)
   );

   pmc_status u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_rst   (ext_rst),
      .sleep_wake(wake_sleep),
      .wdt_wake  (wake_wdt),
      .fail_evt  (fail_evt),
      .slp_flag  (slp_flag),
      .wdt_flag  (wdt_flag),
      .on_frc    (on_frc),
      .fail_trap (fail_trap)
   );

   assign cpu_clk_en = (cur == PM_RUN);
   assign per_clk_en = (cur == PM_RUN) || (cur == PM_IDLE);
   assign osc_en     = (cur != PM_SLEEP) || ((src_q == SRC_LP) && lp_hold && !on_frc);
   assign lprc_en    = (cur != PM_SLEEP) || wdt_en;

   AST_SLEEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_sleep && cpu_clk_en) |=> (!cpu_clk_en && !per_clk_en)); // R3
   AST_WDT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!per_clk_en && !cpu_clk_en && lprc_en == 1'b0 && !irq_wake && !ext_rst)
      |=> !cpu_clk_en); // R4
endmodule

// File: tb/tb_pwr_mode_ctl.sv
module tb_pwr_mode_ctl;
   localparam int TP = 3, TO = 5, TL = 4, TW = 6;
   localparam int NV = 5;
   // vector: {src[1:0], lp_hold, expected cycles to release[7:0]}
   localparam logic [10:0] VEC [NV] = '{
      {2'd0, 1'b0, 8'(1 + TP)},
      {2'd1, 1'b0, 8'(1 + TP + TO + TW)},
      {2'd2, 1'b0, 8'(1 + TP + TO + TL + TW)},
      {2'd3, 1'b1, 8'(1 + TP)},
      {2'd3, 1'b0, 8'(1 + TP + TO + TW)}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic ext_rst = 0, cmd_valid = 0, cmd_sleep = 0, lp_hold = 0, irq_wake = 0;
   logic wdt_en = 0, wdt_timeout = 0, osc_ready = 1, pll_lock = 1, fscm_en = 0;
   logic [1:0] src_sel = 2'd0;
   logic cpu_clk_en, per_clk_en, osc_en, lprc_en, slp_flag, wdt_flag, on_frc, fail_trap;
   int n_chk = 0, n_fail = 0, n_trap = 0;

   always #10 clk = ~clk;

   pwr_mode_ctl #(.T_POR(TP), .T_OST(TO), .T_LOCK(TL), .T_PWRT(TW)) dut (
      .clk, .rst_n, .ext_rst, .cmd_valid, .cmd_sleep, .src_sel, .lp_hold, .irq_wake,
      .wdt_en, .wdt_timeout, .osc_ready, .pll_lock, .fscm_en, .cpu_clk_en, .per_clk_en,
      .osc_en, .lprc_en, .slp_flag, .wdt_flag, .on_frc, .fail_trap);

   always @(posedge clk) if (fail_trap) n_trap++;

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cmd(logic slp);
      @(negedge clk); cmd_valid = 1; cmd_sleep = slp;
      @(negedge clk); cmd_valid = 0;
   endtask

   // pulse a wake input for one edge, return edges until cpu clock seen
   task automatic wake(int kind, output int n);
      @(negedge clk);
      if (kind == 0) irq_wake = 1; else if (kind == 1) wdt_timeout = 1; else ext_rst = 1;
      n = 0;
      for (int i = 0; i < 200; i++) begin
         @(posedge clk); n++;
         @(negedge clk); irq_wake = 0; wdt_timeout = 0; ext_rst = 0;
         if (cpu_clk_en) break;
      end
   endtask

   task automatic por();
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      @(negedge clk);
   endtask

   initial begin
      #(20 * 20000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      chk("R11 cpu", cpu_clk_en, 1); chk("R11 per", per_clk_en, 1);
      chk("R11 osc", osc_en, 1);
      chk("R11 flags", {slp_flag, wdt_flag, on_frc, fail_trap}, 0);

      // table of wake paths (R5 R6 R7)
      for (int v = 0; v < NV; v++) begin
         src_sel = VEC[v][10:9]; lp_hold = VEC[v][8];
         cmd(1'b1);
         chk("R1 sleep entered", {cpu_clk_en, per_clk_en}, 0);
         chk("R3 osc off unless lp held", osc_en, (VEC[v][10:9] == 2'd3) && VEC[v][8]);
         wake(0, n);
         chk(v == 2 ? "R7 pll delay" : (VEC[v][7:0] == 8'(1 + TP) ? "R5 short delay" : "R6 xtal delay"),
             n, int'(VEC[v][7:0]));
      end
      lp_hold = 0;
      chk("R8 slp_flag after sleep wake", slp_flag, 1);
      chk("R8 wdt_flag not set by irq", wdt_flag, 0);

      // watchdog wake and masking (R3 R4 R8)
      src_sel = 2'd0; wdt_en = 1;
      cmd(1'b1);
      chk("R3 lprc kept with wdt", lprc_en, 1);
      wake(1, n);
      chk("R4 wdt wake delay", n, 1 + TP);
      chk("R8 wdt_flag", wdt_flag, 1);
      wdt_en = 0;
      cmd(1'b1);
      chk("R3 lprc off without wdt", lprc_en, 0);
      @(negedge clk); wdt_timeout = 1; @(negedge clk); wdt_timeout = 0;
      repeat (5) @(negedge clk);
      chk("R4 masked timeout ignored", cpu_clk_en, 0);
      cmd(1'b0);
      chk("R1 command in sleep ignored", per_clk_en, 0);
      wake(2, n);
      chk("R4 ext_rst wake", n, 1 + TP);

      // power-on reset clears flags, ext_rst in run sets slp_flag
      por();
      chk("R8 por clears", {slp_flag, wdt_flag}, 0);
      @(negedge clk); ext_rst = 1; @(negedge clk); ext_rst = 0;
      chk("R8 ext_rst in run sets slp_flag", slp_flag, 1);
      chk("R8 ext_rst keeps run", cpu_clk_en, 1);
      por();

      // idle (R2)
      cmd(1'b0);
      chk("R2 idle cpu off", cpu_clk_en, 0); chk("R2 idle per on", per_clk_en, 1);
      cmd(1'b1);
      chk("R1 sleep cmd in idle ignored", per_clk_en, 1);
      @(negedge clk); irq_wake = 1; @(negedge clk); irq_wake = 0;
      chk("R2 idle irq returns run", cpu_clk_en, 1);
      chk("R2 idle wake not sleep flag", slp_flag, 0);

      // not ready, no fail-safe (R10)
      src_sel = 2'd1; osc_ready = 0; fscm_en = 0;
      cmd(1'b1);
      wake(0, n);
      chk("R10 halted while not ready", cpu_clk_en, 0);
      osc_ready = 1;
      @(negedge clk);
      chk("R10 release after ready", cpu_clk_en, 1);
      chk("R10 no trap", n_trap, 0);

      // PLL not locked holds too (R7)
      src_sel = 2'd2; pll_lock = 0;
      cmd(1'b1);
      wake(0, n);
      chk("R7 unlocked pll holds", cpu_clk_en, 0);
      pll_lock = 1;
      @(negedge clk);
      chk("R7 lock releases", cpu_clk_en, 1);

      // fail-safe fallback (R9)
      src_sel = 2'd1; osc_ready = 0; fscm_en = 1;
      cmd(1'b1);
      wake(0, n);
      chk("R9 fallback delay", n, 1 + TP + TO + TW);
      @(negedge clk);
      chk("R9 one trap pulse", n_trap, 1);
      chk("R9 on_frc", on_frc, 1);
      cmd(1'b1);
      wake(0, n);
      chk("R9 later wake short path", n, 1 + TP);
      chk("R9 no second trap", n_trap, 1);

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule